// File: doc/BRIEF.md
# Interrupt Enable and Status Register for an Audio Front-End

This block is one 8-bit location in the register bank of an audio front-end. A host write to it loads the interrupt-enable bits. A host read from it returns the latched interrupt status and clears that status in the same access. The enable bits are write-only: no read path returns them.

Five sources feed the register. Three are level flags: headphone over-current, voice-activation threshold and microphone/headphone connect. One is a change detector on the LRCK-present indication. The last bit is a read-only copy of LRCK-present itself. Each latched source is a small two-state machine. A source in `SRC_IDLE` moves to `SRC_LATCHED` when its enable is armed and its event is seen ("set"). It returns to `SRC_IDLE` on a clearing read with no new event ("clear"), or at once when its stage powers up ("release"). Release wins over a new event, and a new event wins over a clearing read. The interrupt output is the OR of the latched sources whose enables are set.

A simple strobe interface stands in for the serial host bus. `wr_en` carries `wr_data`. `rd_en` captures the read word into `rd_data` at the clock edge, and `rd_data` holds it until the next read.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, all enable bits and all status bits are 0, `irq` is 0 and `rd_data` is 8'h00.
- R2: A write stores enables for bits 5, 3, 2, 1 and 0 from `wr_data`. Bits 7, 6 and 4 of `wr_data` are ignored. A read never returns the enable values.
- R3: One clock after `rd_en`, `rd_data` holds the read word: {2'b00, over-current status, LRCK-present, change status, voice status, mic status, headphone status}. `rd_data` is unchanged by cycles without `rd_en`. The read clears the latched status bits.
- R4: A status bit latches only while its enable is 1. An event in the same cycle as a clearing read stays latched and appears in the next read.
- R5: A level source that is still active after a clearing read sets its status bit again on the next clock.
- R6: Bit 3 sets on either a rising or a falling transition of `lrck_present`. Bit 4 of the read word is the live value of `lrck_present` at the read.
- R7: Microphone connect (bit 1) latches only while `mic_powered` is 0. A 1 on `mic_powered` clears the bit on the next clock.
- R8: Headphone connect (bit 0) latches only while `hp_powered` is 0. A 1 on `hp_powered` clears the bit on the next clock.
- R9: Over-current (bit 5) latches only when its enable is 1 and `hp_powered` is 1.
- R10: `irq` is 1 exactly when some latched status bit has its enable set. Clearing the enable drops `irq` without clearing the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write word, enable bits |
| rd_en | input | 1 | Read strobe, clears status |
| rd_data | output | 8 | Captured read word |
| ovc_flag | input | 1 | Headphone over-current flag |
| lrck_present | input | 1 | LRCK presence indication |
| vox_flag | input | 1 | Voice-activation threshold flag |
| mic_detect | input | 1 | Microphone connected |
| hp_detect | input | 1 | Headphone connected |
| mic_powered | input | 1 | Microphone stage powered up |
| hp_powered | input | 1 | Headphone stage powered up |
| irq | output | 1 | Interrupt request |

## Verification
A source machine stuck in `SRC_LATCHED` shows as `irq` staying high after a clearing read. It also shows as a repeated bit in the next `rd_data`, one read later. A lost set or a missed release shows at `irq` one clock after the event or the power-up, so the bench's per-clock model comparison catches it within one cycle. A wrong enable or a wrong edge detector shows only when the matching source fires. For that reason each source is driven both with and without its enable.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_LATCHED = 1'b1
    } src_state_t;

    localparam int B_HP   = 0;
    localparam int B_MIC  = 1;
    localparam int B_VOX  = 2;
    localparam int B_CHG  = 3;
    localparam int B_LIVE = 4;
    localparam int B_OVC  = 5;
endpackage

// File: rtl/lrck_change_det.sv
module lrck_change_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic change_o
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    always_comb change_o = level_i ^ level_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic event_i,
    input  logic clear_i,
    input  logic release_i,
    output logic pending_o
);
    src_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (!release_i && arm_i && event_i) state_d = SRC_LATCHED;
            end
            SRC_LATCHED: begin
                if (release_i)                           state_d = SRC_IDLE;
                else if (clear_i && !(arm_i && event_i)) state_d = SRC_IDLE;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    always_comb pending_o = (state_q == SRC_LATCHED);

    assert_event_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && event_i && !release_i) |=> pending_o);

    assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !pending_o);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_reg_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             ovc_flag,
    input  logic             lrck_present,
    input  logic             vox_flag,
    input  logic             mic_detect,
    input  logic             hp_detect,
    input  logic             mic_powered,
    input  logic             hp_powered,
    output logic             irq
);
    localparam logic [REG_W-1:0] IMPL_MASK =
        REG_W'((1 << B_OVC) | (1 << B_CHG) | (1 << B_VOX) | (1 << B_MIC) | (1 << B_HP));

    logic [REG_W-1:0] en_q, ev, arm, rel, pend, rd_word;
    logic             lrck_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data & IMPL_MASK;
    end

    lrck_change_det u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (lrck_present),
        .change_o (lrck_chg)
    );

    always_comb begin
        ev         = '0;
        ev[B_OVC]  = ovc_flag;
        ev[B_CHG]  = lrck_chg;
        ev[B_VOX]  = vox_flag;
        ev[B_MIC]  = mic_detect & ~mic_powered;
        ev[B_HP]   = hp_detect & ~hp_powered;
        arm        = en_q;
        arm[B_OVC] = en_q[B_OVC] & hp_powered;
        rel        = '0;
        rel[B_MIC] = mic_powered;
        rel[B_HP]  = hp_powered;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_src
        if (IMPL_MASK[i]) begin : g_cell
            irq_src_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .arm_i     (arm[i]),
                .event_i   (ev[i]),
                .clear_i   (rd_en),
                .release_i (rel[i]),
                .pending_o (pend[i])
            );
        end else begin : g_none
            assign pend[i] = 1'b0;
        end
    end

    always_comb begin
        rd_word         = pend & IMPL_MASK;
        rd_word[B_LIVE] = lrck_present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    always_comb irq = |(pend & en_q);

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_live_lrck_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[B_LIVE] == $past(lrck_present)));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |=> !irq);
endmodule

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ovc_flag = 0, lrck_present = 0, vox_flag = 0;
    logic       mic_detect = 0, hp_detect = 0, mic_powered = 0, hp_powered = 0;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [7:0] m_en, m_st, m_rd;
    logic       m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ovc_flag(ovc_flag),
        .lrck_present(lrck_present), .vox_flag(vox_flag),
        .mic_detect(mic_detect), .hp_detect(hp_detect),
        .mic_powered(mic_powered), .hp_powered(hp_powered), .irq(irq)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_st = 0; m_rd = 0; m_prev = 0;
        end else begin
            logic [7:0] setv;
            setv = 0;
            if (ovc_flag && hp_powered && m_en[5])        setv[5] = 1;
            if ((lrck_present != m_prev) && m_en[3])      setv[3] = 1;
            if (vox_flag && m_en[2])                      setv[2] = 1;
            if (mic_detect && !mic_powered && m_en[1])    setv[1] = 1;
            if (hp_detect && !hp_powered && m_en[0])      setv[0] = 1;
            if (rd_en) begin
                m_rd = m_st;
                m_rd[4] = lrck_present;
            end
            m_st = (rd_en ? 8'h00 : m_st) | setv;
            if (mic_powered) m_st[1] = 0;
            if (hp_powered)  m_st[0] = 0;
            if (wr_en) m_en = wr_data & 8'h2F;
            m_prev = lrck_present;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 rd_data model", rd_data, m_rd);
            check("R10 irq model", {7'b0, irq}, {7'b0, |(m_st & m_en)});
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic do_write(logic [7:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
    endtask

    task automatic do_read();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(); tick();
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        check("R1 reset rd_data", rd_data, 8'h00);
        rst_n = 1; tick();
        do_read();
        check("R1 status zero after reset", rd_data, 8'h00);

        do_write(8'hFF);
        do_read();
        check("R2 no enable readback", rd_data, 8'h00);

        vox_flag = 1; tick(); vox_flag = 0;
        check("R10 irq raised", {7'b0, irq}, 8'h01);
        do_read();
        check("R3 read returns voice", rd_data, 8'h04);
        check("R3 irq cleared by read", {7'b0, irq}, 8'h00);
        do_read();
        check("R3 status cleared", rd_data, 8'h00);

        do_write(8'h2B);
        vox_flag = 1; tick(); vox_flag = 0;
        do_read();
        check("R4 disabled source not latched", rd_data, 8'h00);

        do_write(8'h2F);
        vox_flag = 1; rd_en = 1; tick(); vox_flag = 0; rd_en = 0;
        check("R4 read before event", rd_data, 8'h00);
        do_read();
        check("R4 event during read kept", rd_data, 8'h04);

        vox_flag = 1; tick();
        do_read();
        check("R5 level first read", rd_data, 8'h04);
        do_read();
        check("R5 level re-latched", rd_data, 8'h04);
        vox_flag = 0; tick();
        do_read();
        do_read();
        check("R5 released level clears", rd_data, 8'h00);

        lrck_present = 1; tick();
        do_read();
        check("R6 rising edge and live bit", rd_data, 8'h18);
        do_read();
        check("R6 live bit only", rd_data, 8'h10);
        lrck_present = 0; tick();
        do_read();
        check("R6 falling edge", rd_data, 8'h08);

        mic_detect = 1; tick();
        check("R7 mic irq", {7'b0, irq}, 8'h01);
        mic_powered = 1; tick();
        check("R7 mic released by power-up", {7'b0, irq}, 8'h00);
        do_read();
        check("R7 mic masked while powered", rd_data, 8'h00);
        mic_detect = 0; mic_powered = 0;

        hp_detect = 1; tick();
        do_read();
        check("R8 hp connect latched", rd_data, 8'h01);
        hp_powered = 1; tick();
        do_read();
        check("R8 hp masked while powered", rd_data, 8'h00);
        hp_detect = 0; hp_powered = 0;

        ovc_flag = 1; tick();
        do_read();
        check("R9 ovc gated when stage off", rd_data, 8'h00);
        hp_powered = 1; tick();
        do_read();
        check("R9 ovc latched when stage on", rd_data, 8'h20);
        ovc_flag = 0; tick();
        do_read();
        do_read();
        check("R9 ovc cleared", rd_data, 8'h00);

        vox_flag = 1; tick(); vox_flag = 0;
        do_write(8'h00);
        check("R10 irq dropped by enable clear", {7'b0, irq}, 8'h00);
        do_write(8'h2F);
        check("R10 status kept", {7'b0, irq}, 8'h01);
        do_read();
        check("R10 read after re-enable", rd_data, 8'h04);

        tick(); tick();
        finish_run();
    end
endmodule